// File: doc/BRIEF.md
# Video Frame FIFO Pointer Controller

This block holds the address and flag logic of a dual-clock video frame buffer, together with a small on-chip storage array. A write port on its own clock stores incoming video words at a write pointer. A read port on a second, unrelated clock returns the word at a read pointer. Reading never consumes data, so a stored frame can be replayed as often as needed until it is overwritten. Each pointer runs around a ring whose last address is programmable. Either pointer can be cleared, loaded from a preset, or replaced from a 24-bit external address bus. Write masking freezes the stored picture while the write pointer keeps moving in step with the video.

When detection is enabled, the write port recognises the four-word video timing reference that opens the active region. It then restarts the write pointer at address zero, so each active run lands at the base of the buffer. The pointers cross the clock boundary as gray code through two-flop synchronisers. The write domain compares the two pointers for a near-full flag. The read domain produces a near-empty flag and a collision flag, which is raised when the two pointers meet.

The configuration inputs (`cfg_*`) are expected to be held static while the block runs. The `ovr_en` and `ovr_sel` inputs are driven in the clock domain of the pointer they target.

Top module: `vfb_ptr_ctrl`

## Requirements
- R1: A write cycle (`wr_en`=1, `wr_in_en`=1) stores `wr_data` at the current write pointer, and the pointer then advances by one. A read cycle (`rd_en`=1) places the word at the current read pointer on `rd_data` at the next `rd_clk` edge, and the read pointer then advances by one.
- R2: Reads are non-destructive: reading the same address again returns the same word. While `rd_en` is low, `rd_data` holds its last value.
- R3: A pointer at or above `cfg_last` moves to 0 on its next advance, so the ring holds `cfg_last`+1 words.
- R4: `wr_clr` or `rd_clr` forces its pointer to 0. Clear wins over an override, a set, a timing-reference clear and an advance on the same edge.
- R5: `wr_set` loads the write pointer from `cfg_wr_preset`, and `rd_set` loads the read pointer from `cfg_rd_preset`. Both an override and a clear take priority over a set.
- R6: With `ovr_en`=1, `ovr_sel`=0 replaces the write pointer on a `wr_clk` edge, and `ovr_sel`=1 replaces the read pointer on a `rd_clk` edge. The pointer takes the value of `ovr_addr`. If `ovr_addr` is greater than `cfg_last`, the pointer loads 0 instead.
- R7: A write cycle with `wr_in_en`=0 leaves the stored word unchanged, but the write pointer still advances.
- R8: With `cfg_sync_det`=1, three consecutive accepted words of all ones, all zeros and all zeros, followed by a fourth word whose bit DW-4 (bit 6 at DW=10) is 0, trigger a restart. The fourth word is stored at the current pointer, and the write pointer then goes to 0. The pointer does not restart if that bit is 1 or if `cfg_sync_det`=0.
- R9: `near_full` (write domain) is 1 when the ring distance is at least `cfg_nf_level`. The ring distance is (write pointer − read pointer) modulo (`cfg_last`+1).
- R10: `near_empty` (read domain) is 1 when the same ring distance is at most `cfg_ne_level`.
- R11: `collide` (read domain) is 1 when the read pointer equals the synchronised write pointer.
- R12: After reset, both pointers are 0, `rd_data` is 0, `near_full` is 0 (for `cfg_nf_level` > 0), and `near_empty` and `collide` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| wr_rst_n | input | 1 | Write domain reset, active low |
| wr_en | input | 1 | Write cycle: advance the write pointer |
| wr_in_en | input | 1 | Store enable during a write cycle (0 masks the store) |
| wr_clr | input | 1 | Clear the write pointer to 0 |
| wr_set | input | 1 | Load the write pointer from its preset |
| wr_data | input | DW | Incoming video word |
| rd_clk | input | 1 | Read port clock |
| rd_rst_n | input | 1 | Read domain reset, active low |
| rd_en | input | 1 | Read cycle: fetch and advance the read pointer |
| rd_clr | input | 1 | Clear the read pointer to 0 |
| rd_set | input | 1 | Load the read pointer from its preset |
| rd_data | output | DW | Registered read word |
| ovr_en | input | 1 | External address override strobe |
| ovr_sel | input | 1 | Override target: 0 write pointer, 1 read pointer |
| ovr_addr | input | 24 | External override address |
| cfg_last | input | AW | Last address of the ring |
| cfg_wr_preset | input | AW | Write pointer preset value |
| cfg_rd_preset | input | AW | Read pointer preset value |
| cfg_nf_level | input | AW | Near-full distance threshold |
| cfg_ne_level | input | AW | Near-empty distance threshold |
| cfg_sync_det | input | 1 | Enable timing-reference restart |
| near_full | output | 1 | Distance at or above the near-full level |
| near_empty | output | 1 | Distance at or below the near-empty level |
| collide | output | 1 | Read pointer equals the write pointer |

## Verification
The bench steps the ring distance through every value from 0 to the last address and back to 0. A design with a wrong wrap modulus or an off-by-one comparison would misplace the flag edges at distances 2, 6 and 12. Masked writes are followed by an unmasked write and a read-back. A design that stalled the pointer during masking would put the unmasked word at the wrong address, and one that ignored the mask would overwrite the frozen data.

The pointer controls are driven in conflicting pairs (clear with set, clear with override) to expose a wrong priority order. Out-of-range override addresses expose loads that simply truncate the address. The timing-reference tests send the start-of-active pattern, the end-of-active pattern and the start pattern with detection disabled. A wrong bit position, a wrong flag polarity, or a restart that took effect one word early or late would show up as the wrong word at address 0 or at address 4.

// File: rtl/vfb_pkg.sv
`timescale 1ns/1ps
package vfb_pkg;

    localparam int PTR_W = 24;

    typedef enum logic [2:0] {
        PA_HOLD,
        PA_STEP,
        PA_CLEAR,
        PA_PRESET,
        PA_LOAD_EXT
    } ptr_act_e;

    function automatic logic [PTR_W-1:0] next_ptr(
        input ptr_act_e         act,
        input logic [PTR_W-1:0] cur,
        input logic [PTR_W-1:0] last,
        input logic [PTR_W-1:0] preset,
        input logic [PTR_W-1:0] ext
    );
        logic [PTR_W-1:0] r;
        case (act)
            PA_CLEAR:    r = '0;
            PA_PRESET:   r = preset;
            PA_LOAD_EXT: r = ext;
            PA_STEP:     r = (cur >= last) ? '0 : cur + 1'b1;
            default:     r = cur;
        endcase
        return r;
    endfunction

    function automatic logic [PTR_W-1:0] ring_dist(
        input logic [PTR_W-1:0] ahead,
        input logic [PTR_W-1:0] behind,
        input logic [PTR_W-1:0] last
    );
        if (ahead >= behind)
            return ahead - behind;
        else
            return ahead + last + 1'b1 - behind;
    endfunction

    function automatic logic [PTR_W-1:0] bin_to_gray(input logic [PTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PTR_W-1:0] gray_to_bin(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--)
            b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

endpackage

// File: rtl/vfb_sync.sv
`timescale 1ns/1ps
module vfb_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.s1 = d;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.s2;
endmodule

// File: rtl/vfb_mem.sv
`timescale 1ns/1ps
module vfb_mem #(
    parameter int AW = 4,
    parameter int DW = 10
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store_q[waddr] <= wdata;
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/vfb_wr_ctrl.sv
`timescale 1ns/1ps
module vfb_wr_ctrl
    import vfb_pkg::*;
#(
    parameter int AW      = 4,
    parameter int DW      = 10,
    parameter int TRS_BIT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_in_en,
    input  logic          wr_clr,
    input  logic          wr_set,
    input  logic          ovr_hit,
    input  logic [AW-1:0] ovr_val,
    input  logic [AW-1:0] last_addr,
    input  logic [AW-1:0] preset,
    input  logic [AW-1:0] nf_level,
    input  logic          trs_en,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rp_gray_sync,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] wp_gray,
    output logic          near_full
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] wp_gray;
        logic [DW-1:0] h0;
        logic [DW-1:0] h1;
        logic [DW-1:0] h2;
        logic          nf;
    } wr_state_t;

    wr_state_t     s_d, s_q;
    ptr_act_e      act;
    logic          trs_hit;
    logic [AW-1:0] rp_bin;

    always_comb begin
        s_d     = s_q;
        rp_bin  = AW'(gray_to_bin(PTR_W'(rp_gray_sync)));
        trs_hit = trs_en && wr_en
                  && (s_q.h2 == {DW{1'b1}})
                  && (s_q.h1 == '0)
                  && (s_q.h0 == '0)
                  && !wr_data[TRS_BIT];

        if (wr_clr)       act = PA_CLEAR;
        else if (ovr_hit) act = PA_LOAD_EXT;
        else if (wr_set)  act = PA_PRESET;
        else if (trs_hit) act = PA_CLEAR;
        else if (wr_en)   act = PA_STEP;
        else              act = PA_HOLD;

        s_d.wp      = AW'(next_ptr(act, PTR_W'(s_q.wp), PTR_W'(last_addr),
                                   PTR_W'(preset), PTR_W'(ovr_val)));
        s_d.wp_gray = AW'(bin_to_gray(PTR_W'(s_d.wp)));

        if (wr_en) begin
            s_d.h2 = s_q.h1;
            s_d.h1 = s_q.h0;
            s_d.h0 = wr_data;
        end

        s_d.nf = ring_dist(PTR_W'(s_d.wp), PTR_W'(rp_bin), PTR_W'(last_addr))
                 >= PTR_W'(nf_level);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_we    = wr_en && wr_in_en;
    assign mem_addr  = s_q.wp;
    assign mem_wdata = wr_data;
    assign wp_gray   = s_q.wp_gray;
    assign near_full = s_q.nf;

    // R4: a clear always lands the write pointer on zero
    a_r4_wr_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (s_q.wp == '0));

    // R6: an override without a clear takes the external value
    a_r6_wr_override_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_hit && !wr_clr) |=> (s_q.wp == $past(ovr_val)));

    // R3: a plain advance from the last address returns to zero
    a_r3_wr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_clr && !ovr_hit && !wr_set && !trs_hit && (s_q.wp >= last_addr))
        |=> (s_q.wp == '0));
endmodule

// File: rtl/vfb_rd_ctrl.sv
`timescale 1ns/1ps
module vfb_rd_ctrl
    import vfb_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          rd_clr,
    input  logic          rd_set,
    input  logic          ovr_hit,
    input  logic [AW-1:0] ovr_val,
    input  logic [AW-1:0] last_addr,
    input  logic [AW-1:0] preset,
    input  logic [AW-1:0] ne_level,
    input  logic [AW-1:0] wp_gray_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [AW-1:0] rp_gray,
    output logic [DW-1:0] rd_data,
    output logic          near_empty,
    output logic          collide
);
    typedef struct packed {
        logic [AW-1:0] rp;
        logic [AW-1:0] rp_gray;
        logic [DW-1:0] rdata;
        logic          ne;
        logic          col;
    } rd_state_t;

    rd_state_t     s_d, s_q;
    ptr_act_e      act;
    logic [AW-1:0] wp_bin;

    always_comb begin
        s_d    = s_q;
        wp_bin = AW'(gray_to_bin(PTR_W'(wp_gray_sync)));

        if (rd_clr)       act = PA_CLEAR;
        else if (ovr_hit) act = PA_LOAD_EXT;
        else if (rd_set)  act = PA_PRESET;
        else if (rd_en)   act = PA_STEP;
        else              act = PA_HOLD;

        if (rd_en) s_d.rdata = mem_rdata;

        s_d.rp      = AW'(next_ptr(act, PTR_W'(s_q.rp), PTR_W'(last_addr),
                                   PTR_W'(preset), PTR_W'(ovr_val)));
        s_d.rp_gray = AW'(bin_to_gray(PTR_W'(s_d.rp)));
        s_d.ne      = ring_dist(PTR_W'(wp_bin), PTR_W'(s_d.rp), PTR_W'(last_addr))
                      <= PTR_W'(ne_level);
        s_d.col     = (s_d.rp == wp_bin);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{rp: '0, rp_gray: '0, rdata: '0, ne: 1'b1, col: 1'b1};
        else        s_q <= s_d;
    end

    assign mem_raddr  = s_q.rp;
    assign rp_gray    = s_q.rp_gray;
    assign rd_data    = s_q.rdata;
    assign near_empty = s_q.ne;
    assign collide    = s_q.col;

    // R2: the output word only changes on a read cycle
    a_r2_rd_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(s_q.rdata));

    // R11 with R10: coincident pointers mean zero distance, so near-empty must agree
    a_r11_collide_implies_empty: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.col |-> s_q.ne);

    // R5: a set that is not overruled loads the preset
    a_r5_rd_set_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_set && !rd_clr && !ovr_hit) |=> (s_q.rp == $past(preset)));
endmodule

// File: rtl/vfb_ptr_ctrl.sv
`timescale 1ns/1ps
module vfb_ptr_ctrl #(
    parameter int AW = 4,
    parameter int DW = 10
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic          wr_in_en,
    input  logic          wr_clr,
    input  logic          wr_set,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_en,
    input  logic          rd_clr,
    input  logic          rd_set,
    output logic [DW-1:0] rd_data,
    input  logic          ovr_en,
    input  logic          ovr_sel,
    input  logic [23:0]   ovr_addr,
    input  logic [AW-1:0] cfg_last,
    input  logic [AW-1:0] cfg_wr_preset,
    input  logic [AW-1:0] cfg_rd_preset,
    input  logic [AW-1:0] cfg_nf_level,
    input  logic [AW-1:0] cfg_ne_level,
    input  logic          cfg_sync_det,
    output logic          near_full,
    output logic          near_empty,
    output logic          collide
);
    localparam int SYNC_BIT = DW - 4;

    logic          ovr_in_range;
    logic [AW-1:0] ovr_val;
    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [AW-1:0] wp_gray, wp_gray_rd;
    logic [AW-1:0] rp_gray, rp_gray_wr;

    assign ovr_in_range = (ovr_addr <= 24'(cfg_last));
    assign ovr_val      = ovr_in_range ? ovr_addr[AW-1:0] : '0;

    vfb_wr_ctrl #(.AW(AW), .DW(DW), .TRS_BIT(SYNC_BIT)) wr_ctrl_i (
        .clk          (wr_clk),
        .rst_n        (wr_rst_n),
        .wr_en        (wr_en),
        .wr_in_en     (wr_in_en),
        .wr_clr       (wr_clr),
        .wr_set       (wr_set),
        .ovr_hit      (ovr_en && !ovr_sel),
        .ovr_val      (ovr_val),
        .last_addr    (cfg_last),
        .preset       (cfg_wr_preset),
        .nf_level     (cfg_nf_level),
        .trs_en       (cfg_sync_det),
        .wr_data      (wr_data),
        .rp_gray_sync (rp_gray_wr),
        .mem_we       (mem_we),
        .mem_addr     (mem_waddr),
        .mem_wdata    (mem_wdata),
        .wp_gray      (wp_gray),
        .near_full    (near_full)
    );

    vfb_rd_ctrl #(.AW(AW), .DW(DW)) rd_ctrl_i (
        .clk          (rd_clk),
        .rst_n        (rd_rst_n),
        .rd_en        (rd_en),
        .rd_clr       (rd_clr),
        .rd_set       (rd_set),
        .ovr_hit      (ovr_en && ovr_sel),
        .ovr_val      (ovr_val),
        .last_addr    (cfg_last),
        .preset       (cfg_rd_preset),
        .ne_level     (cfg_ne_level),
        .wp_gray_sync (wp_gray_rd),
        .mem_rdata    (mem_rdata),
        .mem_raddr    (mem_raddr),
        .rp_gray      (rp_gray),
        .rd_data      (rd_data),
        .near_empty   (near_empty),
        .collide      (collide)
    );

    vfb_sync #(.W(AW)) wp_to_rd_i (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wp_gray),
        .q     (wp_gray_rd)
    );

    vfb_sync #(.W(AW)) rp_to_wr_i (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rp_gray),
        .q     (rp_gray_wr)
    );

    vfb_mem #(.AW(AW), .DW(DW)) mem_i (
        .wclk  (wr_clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    // R7: a masked write cycle must never reach the storage array
    a_r7_mask_blocks_store: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && !wr_in_en) |-> !mem_we);
endmodule

// File: tb/vfb_ptr_ctrl_tb_top.sv
`timescale 1ns/1ps
module vfb_ptr_ctrl_tb_top;
    localparam int AW   = 4;
    localparam int DW   = 10;
    localparam int LAST = 11;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_in_en = 1'b1, wr_clr = 1'b0, wr_set = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0, rd_clr = 1'b0, rd_set = 1'b0;
    logic [DW-1:0] rd_data;
    logic          ovr_en = 1'b0, ovr_sel = 1'b0;
    logic [23:0]   ovr_addr = '0;
    logic [AW-1:0] cfg_last = AW'(LAST);
    logic [AW-1:0] cfg_wr_preset = 4'd5, cfg_rd_preset = 4'd5;
    logic [AW-1:0] cfg_nf_level = 4'd6, cfg_ne_level = 4'd2;
    logic          cfg_sync_det = 1'b0;
    logic          near_full, near_empty, collide;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 wr_clk = ~wr_clk;
    always #6 rd_clk = ~rd_clk;

    vfb_ptr_ctrl #(.AW(AW), .DW(DW)) dut_i (.*);

    function automatic logic [DW-1:0] pat(input int k);
        return DW'(k * 13 + 1);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge rd_clk);
        repeat (6) @(posedge wr_clk);
    endtask

    task automatic wr_word(input logic [DW-1:0] d, input logic keep);
        @(negedge wr_clk);
        wr_en = 1'b1; wr_in_en = keep; wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0; wr_in_en = 1'b1;
    endtask

    task automatic wr_ctl(input logic c, input logic s);
        @(negedge wr_clk);
        wr_clr = c; wr_set = s;
        @(negedge wr_clk);
        wr_clr = 1'b0; wr_set = 1'b0;
    endtask

    task automatic rd_ctl(input logic c, input logic s);
        @(negedge rd_clk);
        rd_clr = c; rd_set = s;
        @(negedge rd_clk);
        rd_clr = 1'b0; rd_set = 1'b0;
    endtask

    task automatic wr_ovr(input logic [23:0] a);
        @(negedge wr_clk);
        ovr_en = 1'b1; ovr_sel = 1'b0; ovr_addr = a;
        @(negedge wr_clk);
        ovr_en = 1'b0;
    endtask

    task automatic rd_ovr(input logic [23:0] a);
        @(negedge rd_clk);
        ovr_en = 1'b1; ovr_sel = 1'b1; ovr_addr = a;
        @(negedge rd_clk);
        ovr_en = 1'b0; ovr_sel = 1'b0;
    endtask

    task automatic rd_word(output logic [DW-1:0] d);
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] got;
        repeat (4) @(posedge rd_clk);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;
        settle();

        // R12: reset state
        @(negedge wr_clk); check("R12 near_full", near_full, 0);
        @(negedge rd_clk);
        check("R12 near_empty", near_empty, 1);
        check("R12 collide", collide, 1);
        check("R12 rd_data", rd_data, 0);

        // R9 R10 R11 R3: sweep the ring distance 1..11 then back to 0
        for (int n = 1; n <= LAST + 1; n++) begin
            wr_word(pat(n - 1), 1'b1);
            settle();
            @(negedge wr_clk);
            check("R9 near_full sweep", near_full, ((n % (LAST + 1)) >= 6) ? 1 : 0);
            @(negedge rd_clk);
            check("R10 near_empty sweep", near_empty, ((n % (LAST + 1)) <= 2) ? 1 : 0);
            check("R11 collide sweep", collide, ((n % (LAST + 1)) == 0) ? 1 : 0);
        end

        // R1: read the whole ring back
        for (int k = 0; k <= LAST; k++) begin
            rd_word(got);
            check("R1 read data", got, pat(k));
        end
        settle();
        @(negedge rd_clk); check("R3 read wrap collide", collide, 1);

        // R2: second pass returns the same words; output holds when idle
        for (int k = 0; k <= LAST; k++) begin
            rd_word(got);
            check("R2 reread data", got, pat(k));
        end
        repeat (5) @(negedge rd_clk);
        check("R2 idle hold", rd_data, pat(LAST));

        // R7: masked writes keep the old words but still move the pointer
        wr_ctl(1'b1, 1'b0);
        rd_ctl(1'b1, 1'b0);
        for (int k = 0; k < 3; k++) wr_word(10'h155, 1'b0);
        wr_word(10'h0AA, 1'b1);
        for (int k = 0; k < 3; k++) begin
            rd_word(got);
            check("R7 masked word kept", got, pat(k));
        end
        rd_word(got);
        check("R7 pointer advanced under mask", got, 10'h0AA);

        // R5: preset loads
        wr_ctl(1'b0, 1'b1);
        wr_word(10'h2C3, 1'b1);
        rd_ctl(1'b0, 1'b1);
        rd_word(got); check("R5 preset write/read", got, 10'h2C3);
        rd_word(got); check("R5 next after preset", got, pat(6));

        // R6: external override, in range and out of range
        wr_ovr(24'h000009);
        wr_word(10'h1E1, 1'b1);
        rd_ovr(24'h000009);
        rd_word(got); check("R6 override write/read", got, 10'h1E1);
        rd_word(got); check("R6 next after override", got, pat(10));
        wr_ovr(24'h100003);
        wr_word(10'h0F0, 1'b1);
        rd_ctl(1'b1, 1'b0);
        rd_word(got); check("R6 wr out-of-range goes to 0", got, 10'h0F0);
        rd_ovr(24'h00000C);
        rd_word(got); check("R6 rd out-of-range goes to 0", got, 10'h0F0);

        // R4: clear beats set and override
        wr_ctl(1'b1, 1'b1);
        wr_word(10'h077, 1'b1);
        rd_ctl(1'b1, 1'b1);
        rd_word(got); check("R4 clear over set", got, 10'h077);
        @(negedge wr_clk);
        wr_clr = 1'b1; ovr_en = 1'b1; ovr_sel = 1'b0; ovr_addr = 24'h000007;
        @(negedge wr_clk);
        wr_clr = 1'b0; ovr_en = 1'b0;
        wr_word(10'h099, 1'b1);
        rd_ctl(1'b1, 1'b0);
        rd_word(got); check("R4 clear over override", got, 10'h099);
        rd_ovr(24'h000007);
        rd_word(got); check("R4 override address untouched", got, pat(7));

        // R8: start-of-active reference restarts the write pointer
        cfg_sync_det = 1'b1;
        wr_ctl(1'b1, 1'b0);
        wr_word(10'h3FF, 1'b1); wr_word(10'h000, 1'b1); wr_word(10'h000, 1'b1);
        wr_word(10'h200, 1'b1); wr_word(10'h111, 1'b1);
        rd_ctl(1'b1, 1'b0);
        rd_word(got); check("R8 restart word at 0", got, 10'h111);
        rd_word(got); check("R8 header kept at 1", got, 10'h000);
        rd_ovr(24'h000003);
        rd_word(got); check("R8 status word stored", got, 10'h200);

        // R8: end-of-active reference (bit 6 = 1) does not restart
        wr_ctl(1'b1, 1'b0);
        wr_word(10'h3FF, 1'b1); wr_word(10'h000, 1'b1); wr_word(10'h000, 1'b1);
        wr_word(10'h274, 1'b1); wr_word(10'h122, 1'b1);
        rd_ctl(1'b1, 1'b0);
        rd_word(got); check("R8 end marker no restart addr0", got, 10'h3FF);
        rd_ovr(24'h000004);
        rd_word(got); check("R8 end marker word at 4", got, 10'h122);

        // R8: detection disabled
        cfg_sync_det = 1'b0;
        wr_ctl(1'b1, 1'b0);
        wr_word(10'h3FF, 1'b1); wr_word(10'h000, 1'b1); wr_word(10'h000, 1'b1);
        wr_word(10'h200, 1'b1); wr_word(10'h133, 1'b1);
        rd_ctl(1'b1, 1'b0);
        rd_word(got); check("R8 disabled addr0", got, 10'h3FF);
        rd_ovr(24'h000004);
        rd_word(got); check("R8 disabled word at 4", got, 10'h133);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule